// File: doc/BRIEF.md
# Permission-Checked Cache Hit Stage

This block is the last stage of a load/store pipeline with a private data cache. An earlier stage has already picked one request and read the tag and two permission bits (may-read, may-write) of every way in the addressed set. This stage compares the tags, decides from the permissions alone whether the access hits, and then reads or writes its own data array. No coherence state is kept. The permissions are the only per-line state that decides hit or miss.

A load hit returns the line to writeback together with the thread id. A store hit merges its bytes into the line under a byte-enable mask. A load or store that misses is reported to the cache controller with its thread and address. The same cycle raises a one-hot sleep request for that thread and hands the complete request back to the recycle buffer for a later retry. A store that matches a tag but lacks may-write counts as a miss, so the controller can grant the upgrade. A flush that finds its line emits the line address and data for write-back. A controller update writes a whole line. When the update is marked as an eviction, the old line's address and data are emitted first.

All results are registered: a request presented at clock edge N shows its outputs for exactly one cycle after edge N. The address is `{tag, set}`, with the set index in the low bits. The operation code `req_op` is 0 = load, 1 = store, 2 = flush and 3 = no operation. The upstream arbiter never presents a request and a controller update in the same cycle.

Top module: `lsu_hit_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, all of `ld_valid`, `miss_valid`, `rcy_valid`, `flush_out`, `evict_out` and `sleep_mask` are zero after that edge.
- R2: A load (`req_op`=0) whose tag equals a way's tag, where that way has may-read set, raises `ld_valid` for one cycle. It carries `ld_thread` = `req_thread` and `ld_data` = that line's current contents.
- R3: A load whose tag matches no way, or matches a way without may-read, is a miss regardless of may-write. Non-matching ways never produce a hit, whatever their permissions.
- R4: A store (`req_op`=1) that matches a way with may-write replaces exactly the bytes whose `req_be` bit is set (bit b selects bits 8b+7..8b). It raises no event output.
- R5: A store that matches a way lacking may-write, or matches no way, is a miss.
- R6: A miss raises `miss_valid` with `miss_thread` = `req_thread` and `miss_addr` = `{req_tag, req_set}`. In the same cycle `sleep_mask` has only bit `req_thread` set. `sleep_mask` is zero in every cycle without a miss.
- R7: A miss raises `rcy_valid` with `rcy_store` = 1 for a store, and `rcy_wdata` and `rcy_be` equal to the request's data and byte enables.
- R8: A flush (`req_op`=2) that matches a way with either permission raises `flush_out`, with `wb_addr` = `{req_tag, req_set}` and `wb_data` = that line. A flush that matches nothing raises no output and is not a miss.
- R9: `upd_valid` writes `upd_data` into line (`upd_set`, `upd_way`). If `upd_evict` is also set, `evict_out` rises with `wb_addr` = `{upd_old_tag, upd_set}` and `wb_data` = the line before the write.
- R10: At most one of `ld_valid`, `miss_valid`, `flush_out` and `evict_out` is high in any cycle. `req_valid` and `upd_valid` are never high together.
- R11: Every event output is high for exactly the one cycle after the edge that sampled its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 flush, 3 none |
| req_thread | input | TID_W | Requesting thread |
| req_tag | input | TAG_W | Request tag |
| req_set | input | SET_W | Set index |
| req_wdata | input | LINE_W | Store data |
| req_be | input | LINE_BYTES | Store byte enables |
| way_tag | input | WAYS*TAG_W | Tags of the set, way w at bits w*TAG_W |
| way_rd | input | WAYS | May-read permission per way |
| way_wr | input | WAYS | May-write permission per way |
| upd_valid | input | 1 | Controller line write |
| upd_evict | input | 1 | Emit old line before the write |
| upd_set | input | SET_W | Set of the updated line |
| upd_way | input | WAY_W | Way of the updated line |
| upd_old_tag | input | TAG_W | Tag of the line being evicted |
| upd_data | input | LINE_W | New line contents |
| ld_valid | output | 1 | Load hit result valid |
| ld_thread | output | TID_W | Thread of the load hit |
| ld_data | output | LINE_W | Loaded line |
| miss_valid | output | 1 | Miss event |
| miss_thread | output | TID_W | Thread that missed |
| miss_addr | output | TAG_W+SET_W | Missed address `{tag,set}` |
| sleep_mask | output | THREADS | One-hot sleep request |
| rcy_valid | output | 1 | Request handed back for retry |
| rcy_store | output | 1 | Recycled request is a store |
| rcy_wdata | output | LINE_W | Recycled store data |
| rcy_be | output | LINE_BYTES | Recycled byte enables |
| flush_out | output | 1 | Flush hit event |
| evict_out | output | 1 | Eviction event |
| wb_addr | output | TAG_W+SET_W | Write-back address |
| wb_data | output | LINE_W | Write-back line data |

## Verification
The hardest case is a tag that matches while the permission needed by the operation is missing, and a neighbouring way holds full permissions. A design that checks permissions apart from the tag match would wrongly hit there. The bench reaches this case on purpose. It sweeps every set, every operation, every choice of matching way (or none) and all four permission pairs of the matching way, while every non-matching way holds both permissions. Store hits during the sweep change line contents. The eviction and final read-back passes then expose those changes, so byte-merge errors appear even though a store hit has no output of its own.

// File: rtl/lsu_hit_pkg.sv
// Shared encodings for the permission-checked hit stage.
package lsu_hit_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_FLUSH = 2'd2,
        OP_NONE  = 2'd3
    } lsu_op_e;
endpackage

// File: rtl/lsu_way_match.sv
// Tag compare and permission check across all ways of one set.
// Assumes at most one way of a set holds a given tag; if several
// match, the highest-numbered one is reported.
module lsu_way_match
    import lsu_hit_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int TAG_W = 4,
    parameter int WAY_W = 1
) (
    input  logic [1:0]            op,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic [WAYS*TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]       way_rd,
    input  logic [WAYS-1:0]       way_wr,
    output logic                  hit,
    output logic [WAY_W-1:0]      hit_way
);
    logic [WAYS-1:0] tag_eq;
    logic [WAYS-1:0] perm_ok;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        // compare this way's tag and select the permission the operation needs
        assign tag_eq[w]  = (way_tag[w*TAG_W +: TAG_W] == req_tag);
        assign perm_ok[w] = (op == OP_LOAD)  ? way_rd[w] :
                            (op == OP_STORE) ? way_wr[w] :
                            (op == OP_FLUSH) ? (way_rd[w] | way_wr[w]) : 1'b0;
    end

    // encode the index of the matching way
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (tag_eq[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |(tag_eq & perm_ok);
endmodule

// File: rtl/lsu_line_store.sv
// Data array: one combinational read port and one byte-masked write port.
// Assumes the caller never needs read-after-write within the same cycle.
module lsu_line_store #(
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 4,
    parameter int SET_W      = 2,
    parameter int WAY_W      = 1,
    localparam int LINE_W    = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [SET_W-1:0]      set_idx,
    input  logic [WAY_W-1:0]      way_idx,
    input  logic [LINE_BYTES-1:0] be,
    input  logic [LINE_W-1:0]     wdata,
    output logic [LINE_W-1:0]     rdata
);
    logic [LINE_W-1:0] mem [SETS][WAYS];
    logic [LINE_W-1:0] merged;

    assign rdata = mem[set_idx][way_idx];

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        // take the new byte where enabled, otherwise keep the stored one
        assign merged[b*8 +: 8] = be[b] ? wdata[b*8 +: 8] : rdata[b*8 +: 8];
    end

    // commit the merged line
    always_ff @(posedge clk) begin
        if (we) mem[set_idx][way_idx] <= merged;
    end
endmodule

// File: rtl/lsu_hit_stage.sv
// Hit stage: decides hit or miss from tag match plus per-line permissions,
// accesses the data array, and registers load, miss/recycle/sleep, flush
// and eviction results for one cycle. Assumes the upstream arbiter never
// presents a request together with a controller update.
module lsu_hit_stage
    import lsu_hit_pkg::*;
#(
    parameter int THREADS    = 4,
    parameter int WAYS       = 2,
    parameter int SETS       = 4,
    parameter int TAG_W      = 4,
    parameter int LINE_BYTES = 4,
    localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1,
    localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int ADDR_W = TAG_W + SET_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_op,
    input  logic [TID_W-1:0]      req_thread,
    input  logic [TAG_W-1:0]      req_tag,
    input  logic [SET_W-1:0]      req_set,
    input  logic [LINE_W-1:0]     req_wdata,
    input  logic [LINE_BYTES-1:0] req_be,
    input  logic [WAYS*TAG_W-1:0] way_tag,
    input  logic [WAYS-1:0]       way_rd,
    input  logic [WAYS-1:0]       way_wr,
    input  logic                  upd_valid,
    input  logic                  upd_evict,
    input  logic [SET_W-1:0]      upd_set,
    input  logic [WAY_W-1:0]      upd_way,
    input  logic [TAG_W-1:0]      upd_old_tag,
    input  logic [LINE_W-1:0]     upd_data,
    output logic                  ld_valid,
    output logic [TID_W-1:0]      ld_thread,
    output logic [LINE_W-1:0]     ld_data,
    output logic                  miss_valid,
    output logic [TID_W-1:0]      miss_thread,
    output logic [ADDR_W-1:0]     miss_addr,
    output logic [THREADS-1:0]    sleep_mask,
    output logic                  rcy_valid,
    output logic                  rcy_store,
    output logic [LINE_W-1:0]     rcy_wdata,
    output logic [LINE_BYTES-1:0] rcy_be,
    output logic                  flush_out,
    output logic                  evict_out,
    output logic [ADDR_W-1:0]     wb_addr,
    output logic [LINE_W-1:0]     wb_data
);
    logic                  hit;
    logic [WAY_W-1:0]      hit_way;
    logic                  load_hit, store_hit, flush_hit, access_miss;
    logic                  arr_we;
    logic [SET_W-1:0]      arr_set;
    logic [WAY_W-1:0]      arr_way;
    logic [LINE_BYTES-1:0] arr_be;
    logic [LINE_W-1:0]     arr_wdata, arr_rdata;

    logic                  ld_q, miss_q, flush_q, evict_q;
    logic [THREADS-1:0]    sleep_q;
    logic [TID_W-1:0]      thr_q;
    logic [ADDR_W-1:0]     addr_q, wb_addr_q;
    logic                  store_q;
    logic [LINE_W-1:0]     wdata_q, line_q;
    logic [LINE_BYTES-1:0] be_q;

    lsu_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
        .op      (req_op),
        .req_tag (req_tag),
        .way_tag (way_tag),
        .way_rd  (way_rd),
        .way_wr  (way_wr),
        .hit     (hit),
        .hit_way (hit_way)
    );

    // classify the request into hit kinds and access misses
    always_comb begin
        load_hit    = req_valid && (req_op == OP_LOAD)  && hit;
        store_hit   = req_valid && (req_op == OP_STORE) && hit;
        flush_hit   = req_valid && (req_op == OP_FLUSH) && hit;
        access_miss = req_valid && ((req_op == OP_LOAD) || (req_op == OP_STORE)) && !hit;
    end

    // steer the array port to the controller update or to the request
    always_comb begin
        arr_we    = upd_valid || store_hit;
        arr_set   = upd_valid ? upd_set  : req_set;
        arr_way   = upd_valid ? upd_way  : hit_way;
        arr_be    = upd_valid ? '1       : req_be;
        arr_wdata = upd_valid ? upd_data : req_wdata;
    end

    lsu_line_store #(
        .SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES),
        .SET_W(SET_W), .WAY_W(WAY_W)
    ) u_lines (
        .clk     (clk),
        .we      (arr_we),
        .set_idx (arr_set),
        .way_idx (arr_way),
        .be      (arr_be),
        .wdata   (arr_wdata),
        .rdata   (arr_rdata)
    );

    // event flags, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q    <= 1'b0;
            miss_q  <= 1'b0;
            flush_q <= 1'b0;
            evict_q <= 1'b0;
            sleep_q <= '0;
        end else begin
            ld_q    <= load_hit;
            miss_q  <= access_miss;
            flush_q <= flush_hit;
            evict_q <= upd_valid && upd_evict;
            sleep_q <= access_miss ? (THREADS'(1) << req_thread) : '0;
        end
    end

    // payload captured every cycle; meaningful only beside a flag
    always_ff @(posedge clk) begin
        thr_q     <= req_thread;
        addr_q    <= {req_tag, req_set};
        store_q   <= (req_op == OP_STORE);
        wdata_q   <= req_wdata;
        be_q      <= req_be;
        line_q    <= arr_rdata;
        wb_addr_q <= upd_valid ? {upd_old_tag, upd_set} : {req_tag, req_set};
    end

    assign ld_valid    = ld_q;
    assign ld_thread   = thr_q;
    assign ld_data     = line_q;
    assign miss_valid  = miss_q;
    assign miss_thread = thr_q;
    assign miss_addr   = addr_q;
    assign sleep_mask  = sleep_q;
    assign rcy_valid   = miss_q;
    assign rcy_store   = store_q;
    assign rcy_wdata   = wdata_q;
    assign rcy_be      = be_q;
    assign flush_out   = flush_q;
    assign evict_out   = evict_q;
    assign wb_addr     = wb_addr_q;
    assign wb_data     = line_q;

    assert_sleep_only_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_valid |-> (sleep_mask == '0));
    assert_sleep_names_thread_R6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> (sleep_mask == (THREADS'(1) << miss_thread)));
    assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_valid, miss_valid, flush_out, evict_out}));
    assert_update_alone_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !req_valid);
    assert_miss_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> $past(req_valid));
    assert_flush_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_out |-> $past(req_valid && (req_op == OP_FLUSH)));
    assert_evict_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evict_out |-> $past(upd_valid && upd_evict));
endmodule

// File: tb/sim_lsu_hit_stage.sv
module sim_lsu_hit_stage;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 0;
    logic [1:0]  req_op = 0;
    logic [1:0]  req_thread = 0;
    logic [3:0]  req_tag = 0;
    logic [1:0]  req_set = 0;
    logic [31:0] req_wdata = 0;
    logic [3:0]  req_be = 0;
    logic [7:0]  way_tag = 0;
    logic [1:0]  way_rd = 0, way_wr = 0;
    logic        upd_valid = 0, upd_evict = 0;
    logic [1:0]  upd_set = 0;
    logic        upd_way = 0;
    logic [3:0]  upd_old_tag = 0;
    logic [31:0] upd_data = 0;
    logic        ld_valid, miss_valid, rcy_valid, rcy_store, flush_out, evict_out;
    logic [1:0]  ld_thread, miss_thread;
    logic [31:0] ld_data, rcy_wdata, wb_data;
    logic [5:0]  miss_addr, wb_addr;
    logic [3:0]  sleep_mask, rcy_be;

    lsu_hit_stage u0 (.*);

    int n_chk = 0, n_fail = 0;
    logic [31:0] mdl [4][2];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_check(input string req);
        chk({ld_valid, miss_valid, rcy_valid, flush_out, evict_out} == 5'b0 && sleep_mask == 4'b0,
            req, {ld_valid, miss_valid, rcy_valid, flush_out, evict_out, sleep_mask}, 0);
    endtask

    task automatic do_update(input int s, input int w, input bit ev, input logic [3:0] otag, input logic [31:0] d);
        @(negedge clk);
        upd_valid = 1; upd_evict = ev; upd_set = 2'(s); upd_way = 1'(w);
        upd_old_tag = otag; upd_data = d;
        @(posedge clk);
        @(negedge clk);
        upd_valid = 0;
        if (ev) begin
            chk(evict_out == 1'b1, "R9 evict flag", evict_out, 1);
            chk(wb_addr == {otag, 2'(s)}, "R9 evict address", wb_addr, {otag, 2'(s)});
            chk(wb_data == mdl[s][w], "R9 evict data", wb_data, mdl[s][w]);
        end else begin
            chk(evict_out == 1'b0, "R9 no evict without flag", evict_out, 0);
        end
        mdl[s][w] = d;
    endtask

    // op: 0 load, 1 store, 2 flush; mw: matching way, 2 = none; pr = {may_write, may_read}
    task automatic do_req(input int op, input int thr, input logic [3:0] tg, input int s,
                          input int mw, input logic [1:0] pr, input logic [31:0] wd, input logic [3:0] be);
        bit need, hit;
        @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_thread = 2'(thr); req_tag = tg;
        req_set = 2'(s); req_wdata = wd; req_be = be;
        for (int w = 0; w < 2; w++) begin
            way_tag[w*4 +: 4] = (w == mw) ? tg : (tg ^ 4'(w + 1));
            way_rd[w] = (w == mw) ? pr[0] : 1'b1;
            way_wr[w] = (w == mw) ? pr[1] : 1'b1;
        end
        need = (op == 0) ? pr[0] : (op == 1) ? pr[1] : (pr[0] | pr[1]);
        hit  = (mw < 2) && need;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        if (op == 0 && hit) begin
            chk(ld_valid && !miss_valid, "R2 load hit", {ld_valid, miss_valid}, 2'b10);
            chk(ld_thread == 2'(thr), "R2 load thread", ld_thread, thr);
            chk(ld_data == mdl[s][mw], "R2 load data", ld_data, mdl[s][mw]);
        end else if (op == 1 && hit) begin
            idle_check("R4 store hit raises no event");
            for (int b = 0; b < 4; b++)
                if (be[b]) mdl[s][mw][b*8 +: 8] = wd[b*8 +: 8];
        end else if (op == 2 && hit) begin
            chk(flush_out && !miss_valid, "R8 flush hit flag", {flush_out, miss_valid}, 2'b10);
            chk(wb_addr == {tg, 2'(s)}, "R8 flush address", wb_addr, {tg, 2'(s)});
            chk(wb_data == mdl[s][mw], "R8 flush data", wb_data, mdl[s][mw]);
        end else if (op == 2) begin
            idle_check("R8 flush miss is silent");
        end else begin
            chk(miss_valid && !ld_valid, op == 0 ? "R3 load miss" : "R5 store miss",
                {miss_valid, ld_valid}, 2'b10);
            chk(miss_thread == 2'(thr) && miss_addr == {tg, 2'(s)}, "R6 miss thread/address",
                {miss_thread, miss_addr}, {2'(thr), tg, 2'(s)});
            chk(sleep_mask == 4'(1 << thr), "R6 sleep mask", sleep_mask, 4'(1 << thr));
            chk(rcy_valid && rcy_store == (op == 1) && rcy_wdata == wd && rcy_be == be,
                "R7 recycle fields", {rcy_valid, rcy_store, rcy_be, rcy_wdata},
                {1'b1, 1'(op == 1), be, wd});
        end
        @(negedge clk);
        idle_check("R11 event lasts one cycle");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle_check("R1 reset state");
        rst_n = 1;
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                do_update(s, w, 1'b0, 4'h0, 32'hC0DE0000 + 32'(s * 16 + w));
        for (int s = 0; s < 4; s++)
            for (int op = 0; op < 3; op++)
                for (int mw = 0; mw < 3; mw++)
                    for (int p = 0; p < 4; p++)
                        do_req(op, (s + op + p) % 4, 4'((s * 3 + op + mw) % 16), s, mw, 2'(p),
                               32'h5A000000 ^ 32'((s << 12) | (mw << 8) | (p << 4) | op) ^ 32'h00F0F000,
                               4'((p * 5 + mw + s) % 16));
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                do_update(s, w, 1'b1, 4'(s + w + 5), 32'h9E000000 + 32'(s * 256 + w));
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                do_req(0, w + s, 4'(s + 9), s, w, 2'b11, 32'h0, 4'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule